// File: doc/BRIEF.md
# Accumulator Execution Unit with Status Flags

This block is the 8-bit datapath of a single-accumulator controller. On each issued operation it takes three things: the working register value W, a register-file operand R and an 8-bit immediate. From these it forms a result and says where the result goes: back to W, back to the register-file location, or nowhere. It also reports which of the carry, half-carry and zero flags the operation updates, with their new values. A skip request tells the sequencer to discard the next instruction.

The surrounding controller decodes the instruction into an operation class, a destination bit and a 3-bit bit index. It presents the operands and the current carry with a one-cycle issue strobe. One clock later the registered outputs carry the result, the per-destination write enables, the flag write enables and values, and skip. Fetch, the register file and the status register storage sit outside the block. A separate input tells the block when the register operand is the status register itself, so that the result can merge with the new flag values.

Top module: `alu_flag_unit`

## Requirements
- R1: Add forms W + R. Subtract forms R − W as R + ~W + 1. Both update C, HC and Z. C is the carry out of bit 7, so for subtract C = 1 means no borrow. HC is the carry (no-borrow for subtract) out of bit 3. Z is set when the 8-bit result is zero.
- R2: Load-register, increment, decrement, complement, AND, OR and XOR (register or immediate), clear-W and clear-register update only Z, which is set when the result is zero.
- R3: Increment-and-skip and decrement-and-skip write their result with no flag write enable, and raise skip exactly when the result is zero.
- R4: Rotate right sends R bit 0 to C and the incoming carry to bit 7. Rotate left sends R bit 7 to C and the incoming carry to bit 0. Only the C write enable is raised.
- R5: Swap exchanges the upper and lower nibbles of R. Swap, store-W (W to R) and load-immediate (immediate to W) raise no flag write enable.
- R6: For the register-operand forms of R1 to R5, dest = 0 raises only the W write enable and dest = 1 raises only the register write enable. No operation ever raises both.
- R7: Immediate AND, OR and XOR, load-immediate and clear-W always raise the W write enable, whatever dest holds.
- R8: Bit set and bit clear write R with only the bit chosen by the 3-bit index forced to 1 or 0, raise the register write enable and update no flag.
- R9: Test-clear skips when the chosen bit of R is 0. Test-set skips when it is 1. Neither raises any write enable or flag enable.
- R10: When the register write enable is raised and the status-target input was high, each updated flag overrides its bit in the result: C at bit 0, HC at bit 1, Z at bit 2. Z is computed from the result before this override.
- R11: Outputs are registered and show the operation issued on the previous clock. After reset, and on any cycle that follows a clock with no issue, every write enable, flag enable and skip is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | An operation is presented this cycle |
| op_code | input | 5 | Operation class (package enumeration) |
| w_in | input | 8 | Working register value |
| r_in | input | 8 | Register-file operand |
| imm_in | input | 8 | Immediate operand |
| dest | input | 1 | 0: result to W, 1: result to register |
| bit_sel | input | 3 | Bit index for bit operations |
| c_in | input | 1 | Current carry flag |
| r_is_status | input | 1 | Register operand is the status register |
| res | output | 8 | Result value |
| w_we | output | 1 | Write result to W |
| r_we | output | 1 | Write result to register |
| c_we | output | 1 | Carry flag update |
| hc_we | output | 1 | Half-carry flag update |
| z_we | output | 1 | Zero flag update |
| c_out | output | 1 | New carry value |
| hc_out | output | 1 | New half-carry value |
| z_out | output | 1 | New zero value |
| skip | output | 1 | Discard the next instruction |

## Verification
Add runs with operand pairs that carry only out of the low nibble, only out of bit 7, out of both, and wrap to zero, so the C, HC and Z outputs can be told apart. Subtract runs with equal operands, a borrow across bit 7, and a borrow across bit 3 alone. These separate the no-borrow sense of C and HC from an inverted convention. Rotates run with both incoming carry values and with operands whose end bits differ. Bit operations run at indices 0 and 7. A long pseudo-random sequence over every operation class, both dest values and the status-target input covers the rest, and the bench model is compared against the outputs on every clock.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int OPW = 5;

    typedef enum logic [OPW-1:0] {
        OP_NOP, OP_LDR, OP_STWR, OP_LDWI, OP_SWAP, OP_INC, OP_INCSZ,
        OP_ADD, OP_SUB, OP_DEC, OP_DECSZ, OP_AND, OP_ANDI, OP_IOR,
        OP_IORI, OP_XOR, OP_XORI, OP_COM, OP_RRC, OP_RLC, OP_CLRW,
        OP_CLRR, OP_BCLR, OP_BSET, OP_BTSC, OP_BTSS
    } alu_op_e;

    // status register bit positions used when the result targets it
    localparam int FLAG_C_POS  = 0;
    localparam int FLAG_HC_POS = 1;
    localparam int FLAG_Z_POS  = 2;

    typedef enum logic [1:0] {
        DST_NONE, DST_SEL, DST_W, DST_R
    } dst_mode_e;

endpackage

// File: rtl/alu_arith.sv
module alu_arith
    import alu_pkg::*;
#(
    parameter int DW = 8
) (
    input  alu_op_e         op,
    input  logic [DW-1:0]   w_val,
    input  logic [DW-1:0]   r_val,
    output logic [DW-1:0]   sum,
    output logic            carry,
    output logic            half_carry
);
    localparam int HW = DW / 2;

    logic [DW-1:0] addend;
    logic          cin;
    logic [DW:0]   full;
    logic [HW:0]   low;

    always_comb begin
        addend = '0;
        cin    = 1'b0;
        case (op)
            OP_ADD:              begin addend = w_val;  cin = 1'b0; end
            OP_SUB:              begin addend = ~w_val; cin = 1'b1; end
            OP_INC, OP_INCSZ:    begin addend = '0;     cin = 1'b1; end
            OP_DEC, OP_DECSZ:    begin addend = '1;     cin = 1'b0; end
            default:             begin addend = '0;     cin = 1'b0; end
        endcase
        full = {1'b0, r_val} + {1'b0, addend} + {{DW{1'b0}}, cin};
        low  = {1'b0, r_val[HW-1:0]} + {1'b0, addend[HW-1:0]} + {{HW{1'b0}}, cin};
        sum        = full[DW-1:0];
        carry      = full[DW];
        half_carry = low[HW];
    end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import alu_pkg::*;
#(
    parameter int DW = 8,
    localparam int BW = $clog2(DW)
) (
    input  alu_op_e         op,
    input  logic [DW-1:0]   w_val,
    input  logic [DW-1:0]   r_val,
    input  logic [DW-1:0]   imm_val,
    input  logic [BW-1:0]   bit_idx,
    input  logic            c_prev,
    output logic [DW-1:0]   result,
    output logic            c_next,
    output logic            sel_bit
);
    localparam int HW = DW / 2;

    logic [DW-1:0] bit_mask;

    always_comb begin
        bit_mask = '0;
        bit_mask[bit_idx] = 1'b1;
        sel_bit = r_val[bit_idx];
        c_next  = c_prev;
        result  = r_val;
        case (op)
            OP_LDR:  result = r_val;
            OP_STWR: result = w_val;
            OP_LDWI: result = imm_val;
            OP_SWAP: result = {r_val[HW-1:0], r_val[DW-1:HW]};
            OP_AND:  result = r_val & w_val;
            OP_ANDI: result = imm_val & w_val;
            OP_IOR:  result = r_val | w_val;
            OP_IORI: result = imm_val | w_val;
            OP_XOR:  result = r_val ^ w_val;
            OP_XORI: result = imm_val ^ w_val;
            OP_COM:  result = ~r_val;
            OP_RRC: begin
                result = {c_prev, r_val[DW-1:1]};
                c_next = r_val[0];
            end
            OP_RLC: begin
                result = {r_val[DW-2:0], c_prev};
                c_next = r_val[DW-1];
            end
            OP_CLRW, OP_CLRR: result = '0;
            OP_BSET: result = r_val | bit_mask;
            OP_BCLR: result = r_val & ~bit_mask;
            default: result = r_val;
        endcase
    end
endmodule

// File: rtl/alu_flag_merge.sv
module alu_flag_merge
    import alu_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW-1:0] res_raw,
    input  logic          to_reg,
    input  logic          is_status,
    input  logic          c_upd,
    input  logic          hc_upd,
    input  logic          z_upd,
    input  logic          c_val,
    input  logic          hc_val,
    input  logic          z_val,
    output logic [DW-1:0] res_final
);
    always_comb begin
        res_final = res_raw;
        if (to_reg && is_status) begin
            if (c_upd)  res_final[FLAG_C_POS]  = c_val;
            if (hc_upd) res_final[FLAG_HC_POS] = hc_val;
            if (z_upd)  res_final[FLAG_Z_POS]  = z_val;
        end
    end
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
    import alu_pkg::*;
#(
    parameter int DW = 8,
    localparam int BW = $clog2(DW)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue,
    input  logic [OPW-1:0]   op_code,
    input  logic [DW-1:0]    w_in,
    input  logic [DW-1:0]    r_in,
    input  logic [DW-1:0]    imm_in,
    input  logic             dest,
    input  logic [BW-1:0]    bit_sel,
    input  logic             c_in,
    input  logic             r_is_status,
    output logic [DW-1:0]    res,
    output logic             w_we,
    output logic             r_we,
    output logic             c_we,
    output logic             hc_we,
    output logic             z_we,
    output logic             c_out,
    output logic             hc_out,
    output logic             z_out,
    output logic             skip
);
    typedef struct packed {
        logic [DW-1:0] res;
        logic          w_we;
        logic          r_we;
        logic          c_we;
        logic          hc_we;
        logic          z_we;
        logic          c;
        logic          hc;
        logic          z;
        logic          skip;
    } out_t;

    alu_op_e op;
    assign op = alu_op_e'(op_code);

    logic [DW-1:0] ar_sum;
    logic          ar_c, ar_hc;
    logic [DW-1:0] lg_res;
    logic          lg_c, lg_bit;
    logic [DW-1:0] merged;

    logic          use_arith;
    logic [DW-1:0] raw_res;
    dst_mode_e     dmode;
    logic          upd_c, upd_hc, upd_z;
    logic          to_w, to_r;
    logic          c_new, z_new;

    out_t state_d, state_q;

    alu_arith #(.DW(DW)) u_arith (
        .op(op), .w_val(w_in), .r_val(r_in),
        .sum(ar_sum), .carry(ar_c), .half_carry(ar_hc)
    );

    alu_logic #(.DW(DW)) u_logic (
        .op(op), .w_val(w_in), .r_val(r_in), .imm_val(imm_in),
        .bit_idx(bit_sel), .c_prev(c_in),
        .result(lg_res), .c_next(lg_c), .sel_bit(lg_bit)
    );

    alu_flag_merge #(.DW(DW)) u_merge (
        .res_raw(raw_res), .to_reg(to_r), .is_status(r_is_status),
        .c_upd(upd_c), .hc_upd(upd_hc), .z_upd(upd_z),
        .c_val(c_new), .hc_val(ar_hc), .z_val(z_new),
        .res_final(merged)
    );

    // decode: destination mode and flag update set
    always_comb begin
        dmode     = DST_NONE;
        upd_c     = 1'b0;
        upd_hc    = 1'b0;
        upd_z     = 1'b0;
        use_arith = 1'b0;
        case (op)
            OP_ADD, OP_SUB: begin
                dmode = DST_SEL; use_arith = 1'b1;
                upd_c = 1'b1; upd_hc = 1'b1; upd_z = 1'b1;
            end
            OP_INC, OP_DEC: begin
                dmode = DST_SEL; use_arith = 1'b1; upd_z = 1'b1;
            end
            OP_INCSZ, OP_DECSZ: begin
                dmode = DST_SEL; use_arith = 1'b1;
            end
            OP_LDR, OP_AND, OP_IOR, OP_XOR, OP_COM: begin
                dmode = DST_SEL; upd_z = 1'b1;
            end
            OP_SWAP:               dmode = DST_SEL;
            OP_RRC, OP_RLC: begin
                dmode = DST_SEL; upd_c = 1'b1;
            end
            OP_ANDI, OP_IORI, OP_XORI, OP_CLRW: begin
                dmode = DST_W; upd_z = 1'b1;
            end
            OP_LDWI:               dmode = DST_W;
            OP_CLRR: begin
                dmode = DST_R; upd_z = 1'b1;
            end
            OP_STWR, OP_BSET, OP_BCLR: dmode = DST_R;
            default:               dmode = DST_NONE;
        endcase
    end

    always_comb begin
        raw_res = use_arith ? ar_sum : lg_res;
        z_new   = (raw_res == '0);
        c_new   = use_arith ? ar_c : lg_c;
        to_w    = (dmode == DST_W) || (dmode == DST_SEL && !dest);
        to_r    = (dmode == DST_R) || (dmode == DST_SEL && dest);
    end

    always_comb begin
        state_d = '0;
        if (issue) begin
            state_d.res   = merged;
            state_d.w_we  = to_w;
            state_d.r_we  = to_r;
            state_d.c_we  = upd_c;
            state_d.hc_we = upd_hc;
            state_d.z_we  = upd_z;
            state_d.c     = c_new;
            state_d.hc    = ar_hc;
            state_d.z     = z_new;
            case (op)
                OP_INCSZ, OP_DECSZ: state_d.skip = z_new;
                OP_BTSC:            state_d.skip = !lg_bit;
                OP_BTSS:            state_d.skip = lg_bit;
                default:            state_d.skip = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign res    = state_q.res;
    assign w_we   = state_q.w_we;
    assign r_we   = state_q.r_we;
    assign c_we   = state_q.c_we;
    assign hc_we  = state_q.hc_we;
    assign z_we   = state_q.z_we;
    assign c_out  = state_q.c;
    assign hc_out = state_q.hc;
    assign z_out  = state_q.z;
    assign skip   = state_q.skip;
endmodule

// File: rtl/alu_checker.sv
module alu_checker
    import alu_pkg::*;
#(
    parameter int DW = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           issue,
    input logic [OPW-1:0] op_code,
    input logic [DW-1:0]  w_in,
    input logic [DW-1:0]  r_in,
    input logic [DW-1:0]  res,
    input logic           w_we,
    input logic           r_we,
    input logic           c_we,
    input logic           hc_we,
    input logic           z_we,
    input logic           c_out,
    input logic           skip
);
    AST_SINGLE_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        !(w_we && r_we)); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |=> !(w_we || r_we || c_we || hc_we || z_we || skip)); // R11

    AST_SKIPFORM_NOFLAG: assert property (@(posedge clk) disable iff (!rst_n)
        issue && (op_code == OP_INCSZ || op_code == OP_DECSZ)
        |=> !(c_we || hc_we || z_we)); // R3

    AST_SKIPFORM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        issue && (op_code == OP_INCSZ || op_code == OP_DECSZ)
        |=> (skip == (res == '0))); // R3

    AST_IMM_TO_W: assert property (@(posedge clk) disable iff (!rst_n)
        issue && (op_code == OP_ANDI || op_code == OP_IORI || op_code == OP_XORI)
        |=> w_we && !r_we); // R7

    AST_ROTATE_C_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        issue && (op_code == OP_RRC || op_code == OP_RLC)
        |=> c_we && !hc_we && !z_we); // R4

    AST_SUB_NO_BORROW: assert property (@(posedge clk) disable iff (!rst_n)
        issue && op_code == OP_SUB
        |=> c_out == ($past(r_in) >= $past(w_in))); // R1

    AST_TEST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        issue && (op_code == OP_BTSC || op_code == OP_BTSS)
        |=> !(w_we || r_we || c_we || hc_we || z_we)); // R9
endmodule

bind alu_flag_unit alu_checker #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .issue(issue), .op_code(op_code),
    .w_in(w_in), .r_in(r_in), .res(res), .w_we(w_we), .r_we(r_we),
    .c_we(c_we), .hc_we(hc_we), .z_we(z_we), .c_out(c_out), .skip(skip)
);

// File: tb/alu_flag_unit_test.sv
`timescale 1ns/1ps
module alu_flag_unit_test;
    import alu_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       issue = 1'b0;
    logic [4:0] op_code = '0;
    logic [7:0] w_in = '0, r_in = '0, imm_in = '0;
    logic       dest = 1'b0;
    logic [2:0] bit_sel = '0;
    logic       c_in = 1'b0;
    logic       r_is_status = 1'b0;
    logic [7:0] res;
    logic       w_we, r_we, c_we, hc_we, z_we, c_out, hc_out, z_out, skip;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    // expected outputs for the cycle being checked
    int e_res, e_w, e_r, e_cwe, e_hwe, e_zwe, e_c, e_hc, e_z, e_skip;
    string e_tag;

    always #4 clk = ~clk;

    alu_flag_unit uut (
        .clk(clk), .rst_n(rst_n), .issue(issue), .op_code(op_code),
        .w_in(w_in), .r_in(r_in), .imm_in(imm_in), .dest(dest),
        .bit_sel(bit_sel), .c_in(c_in), .r_is_status(r_is_status),
        .res(res), .w_we(w_we), .r_we(r_we), .c_we(c_we), .hc_we(hc_we),
        .z_we(z_we), .c_out(c_out), .hc_out(hc_out), .z_out(z_out), .skip(skip)
    );

    task automatic check1(string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h (op %0d)", e_tag, what, act, exp, op_code);
        end
    endtask

    task automatic compare_all();
        check1("w_we", int'(w_we), e_w);
        check1("r_we", int'(r_we), e_r);
        check1("c_we", int'(c_we), e_cwe);
        check1("hc_we", int'(hc_we), e_hwe);
        check1("z_we", int'(z_we), e_zwe);
        check1("skip", int'(skip), e_skip);
        if (e_w != 0 || e_r != 0) check1("res", int'(res), e_res);
        if (e_cwe != 0) check1("c", int'(c_out), e_c);
        if (e_hwe != 0) check1("hc", int'(hc_out), e_hc);
        if (e_zwe != 0) check1("z", int'(z_out), e_z);
    endtask

    // behavioural reference
    task automatic model(alu_op_e op, int w, int r, int im, int d, int b, int ci, int st);
        int v; int sel; bit flag_z_only; bit tform;
        v = 0; sel = 0;
        e_w = 0; e_r = 0; e_cwe = 0; e_hwe = 0; e_zwe = 0;
        e_c = 0; e_hc = 0; e_skip = 0;
        flag_z_only = 0; tform = 1;
        e_tag = "R2";
        case (op)
            OP_ADD: begin
                v = w + r; e_c = (v > 255); e_hc = ((w % 16) + (r % 16)) > 15;
                e_cwe = 1; e_hwe = 1; e_zwe = 1; e_tag = "R1";
            end
            OP_SUB: begin
                v = r - w; e_c = (r >= w); e_hc = ((r % 16) >= (w % 16));
                e_cwe = 1; e_hwe = 1; e_zwe = 1; e_tag = "R1";
            end
            OP_INC:   begin v = r + 1; flag_z_only = 1; end
            OP_DEC:   begin v = r - 1; flag_z_only = 1; end
            OP_INCSZ: begin v = r + 1; e_tag = "R3"; end
            OP_DECSZ: begin v = r - 1; e_tag = "R3"; end
            OP_LDR:   begin v = r; flag_z_only = 1; end
            OP_AND:   begin v = r & w; flag_z_only = 1; end
            OP_IOR:   begin v = r | w; flag_z_only = 1; end
            OP_XOR:   begin v = r ^ w; flag_z_only = 1; end
            OP_COM:   begin v = 255 - r; flag_z_only = 1; end
            OP_SWAP:  begin v = (r % 16) * 16 + r / 16; e_tag = "R5"; end
            OP_RRC:   begin v = r / 2 + ci * 128; e_c = r % 2; e_cwe = 1; e_tag = "R4"; end
            OP_RLC:   begin v = (r * 2) % 256 + ci; e_c = r / 128; e_cwe = 1; e_tag = "R4"; end
            default:  tform = 0;
        endcase
        if (!tform) begin
            case (op)
                OP_ANDI: begin v = im & w; flag_z_only = 1; e_w = 1; e_tag = "R7"; end
                OP_IORI: begin v = im | w; flag_z_only = 1; e_w = 1; e_tag = "R7"; end
                OP_XORI: begin v = im ^ w; flag_z_only = 1; e_w = 1; e_tag = "R7"; end
                OP_CLRW: begin v = 0; flag_z_only = 1; e_w = 1; e_tag = "R7"; end
                OP_LDWI: begin v = im; e_w = 1; e_tag = "R7"; end
                OP_CLRR: begin v = 0; flag_z_only = 1; e_r = 1; end
                OP_STWR: begin v = w; e_r = 1; e_tag = "R5"; end
                OP_BSET: begin v = r | (1 << b); e_r = 1; e_tag = "R8"; end
                OP_BCLR: begin v = r & ~(1 << b); e_r = 1; e_tag = "R8"; end
                OP_BTSC: begin sel = (r >> b) & 1; e_skip = (sel == 0); e_tag = "R9"; end
                OP_BTSS: begin sel = (r >> b) & 1; e_skip = (sel == 1); e_tag = "R9"; end
                default: e_tag = "R11";
            endcase
        end else begin
            if (d != 0) e_r = 1; else e_w = 1;
        end
        v = v & 255;
        e_z = (v == 0);
        if (flag_z_only) e_zwe = 1;
        if (op == OP_INCSZ || op == OP_DECSZ) e_skip = e_z;
        if (e_r != 0 && st != 0) begin
            if (e_cwe != 0) v = (v & ~1) | e_c;
            if (e_hwe != 0) v = (v & ~2) | (e_hc * 2);
            if (e_zwe != 0) v = (v & ~4) | (e_z * 4);
            e_tag = "R10";
        end
        e_res = v;
    endtask

    task automatic do_op(alu_op_e op, int w, int r, int im, int d, int b, int ci, int st);
        @(negedge clk);
        issue = 1'b1; op_code = op; w_in = w[7:0]; r_in = r[7:0]; imm_in = im[7:0];
        dest = d[0]; bit_sel = b[2:0]; c_in = ci[0]; r_is_status = st[0];
        model(op, w, r, im, d, b, ci, st);
        @(negedge clk);
        issue = 1'b0;
        compare_all();
    endtask

    task automatic idle_cycle(alu_op_e op);
        @(negedge clk);
        issue = 1'b0; op_code = op; r_in = 8'h00;
        e_tag = "R11";
        e_w = 0; e_r = 0; e_cwe = 0; e_hwe = 0; e_zwe = 0; e_skip = 0;
        @(negedge clk);
        compare_all();
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL R11 watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : stim
        int seed;
        repeat (3) @(negedge clk);
        // reset state R11
        e_tag = "R11"; e_w = 0; e_r = 0; e_cwe = 0; e_hwe = 0; e_zwe = 0; e_skip = 0;
        compare_all();
        rst_n = 1'b1;

        do_op(OP_ADD, 8'h01, 8'h0F, 0, 0, 0, 0, 0);   // R1 half carry only
        do_op(OP_ADD, 8'h01, 8'hFF, 0, 1, 0, 0, 0);   // R1 wrap to zero
        do_op(OP_ADD, 8'h80, 8'h90, 0, 0, 0, 0, 0);   // R1 carry only
        do_op(OP_SUB, 8'h05, 8'h05, 0, 0, 0, 0, 0);   // R1 equal
        do_op(OP_SUB, 8'h05, 8'h03, 0, 1, 0, 0, 0);   // R1 borrow
        do_op(OP_SUB, 8'h01, 8'h10, 0, 0, 0, 0, 0);   // R1 nibble borrow
        do_op(OP_INC, 0, 8'hFF, 0, 1, 0, 0, 0);       // R2
        do_op(OP_DEC, 0, 8'h01, 0, 0, 0, 0, 0);       // R2
        do_op(OP_INCSZ, 0, 8'hFF, 0, 1, 0, 0, 0);     // R3 skip
        do_op(OP_DECSZ, 0, 8'h02, 0, 1, 0, 0, 0);     // R3 no skip
        do_op(OP_DECSZ, 0, 8'h01, 0, 0, 0, 0, 0);     // R3 skip
        do_op(OP_RRC, 0, 8'h01, 0, 1, 0, 1, 0);       // R4
        do_op(OP_RLC, 0, 8'h80, 0, 0, 0, 0, 0);       // R4
        do_op(OP_RLC, 0, 8'h40, 0, 1, 0, 1, 0);       // R4
        do_op(OP_SWAP, 0, 8'hA5, 0, 0, 0, 0, 0);      // R5
        do_op(OP_STWR, 8'h3C, 8'h00, 0, 0, 0, 0, 0);  // R5
        do_op(OP_AND, 8'hF0, 8'h0F, 0, 1, 0, 0, 0);   // R6
        do_op(OP_XOR, 8'h55, 8'hFF, 0, 0, 0, 0, 0);   // R6
        do_op(OP_IORI, 8'h01, 0, 8'h80, 1, 0, 0, 0);  // R7 dest ignored
        do_op(OP_ANDI, 8'hFF, 0, 8'h00, 1, 0, 0, 0);  // R7
        do_op(OP_LDWI, 0, 0, 8'h7E, 1, 0, 0, 0);      // R7
        do_op(OP_BSET, 0, 8'h00, 0, 0, 7, 0, 0);      // R8
        do_op(OP_BCLR, 0, 8'hFF, 0, 0, 0, 0, 0);      // R8
        do_op(OP_BTSC, 0, 8'hFE, 0, 0, 0, 0, 0);      // R9 skip
        do_op(OP_BTSS, 0, 8'h80, 0, 0, 7, 0, 0);      // R9 skip
        do_op(OP_BTSS, 0, 8'h7F, 0, 0, 7, 0, 0);      // R9 no skip
        do_op(OP_ADD, 8'h01, 8'hFF, 0, 1, 0, 0, 1);   // R10 all flags merge
        do_op(OP_INC, 0, 8'h18, 0, 1, 0, 0, 1);       // R10 only Z merged
        do_op(OP_ADD, 8'h01, 8'hFF, 0, 0, 0, 0, 1);   // R10 no merge into W
        idle_cycle(OP_BTSC);                          // R11
        idle_cycle(OP_ADD);                           // R11

        seed = 32'h1ACE;
        for (int i = 0; i < 400; i++) begin
            int o;
            seed = (seed * 1103515245 + 12345) & 32'h7FFFFFFF;
            o = (seed >> 8) % 26;
            do_op(alu_op_e'(o), (seed >> 3) & 255, (seed >> 11) & 255, (seed >> 17) & 255,
                  (seed >> 5) & 1, (seed >> 20) & 7, (seed >> 24) & 1, (seed >> 27) & 1);
            if ((i % 37) == 0) idle_cycle(OP_INCSZ);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule